// File: doc/BRIEF.md
# Ethernet receive destination address filter

The filter looks at the 48-bit destination address of a received frame and decides whether the frame is kept or thrown away. First it sorts the address into one of three classes: unicast, multicast or broadcast. It then applies the rule for that class. A unicast address is compared with the programmed station address, and the promiscuous enable can override a mismatch. A broadcast address is kept only when broadcast reception or promiscuous mode is enabled. A multicast address is filtered through a 64-bit hash table, which is indexed by a CRC computed over the address.

The receive path presents the address together with a one-cycle `da_valid_i` strobe. One cycle later the filter returns the decision and the class flags, qualified by `dec_valid_o`. Software fills the hash table one 8-bit row at a time through a row write port.

Top module: `eth_da_filter`

## Requirements
- R1: An address of all ones is broadcast. An address whose first wire byte `da_i[47:40]` has bit 0 (`da_i[40]`) set, and which is not all ones, is multicast. Every other address is unicast. Whenever `dec_valid_o` is high, exactly one of `is_ucast_o`, `is_mcast_o` and `is_bcast_o` is high.
- R2: A `da_valid_i` pulse sampled at a clock edge makes `dec_valid_o` high for exactly the following cycle. `accept_o` and the class flags describe that address during that cycle.
- R3: A unicast address is accepted when it equals `station_addr_i`. When it differs, it is accepted only if `promisc_i` is high.
- R4: A broadcast address is accepted when `promisc_i` or `rx_bc_i` is high, and discarded when both are low.
- R5: With `rx_all_mc_i` low, a multicast address is discarded unless `pause_i` is high, in which case it is accepted.
- R6: With `rx_all_mc_i` high, a multicast address is decided by the hash table. The CRC register starts at 0xFFFFFFFF and processes the bytes `da_i[47:40]` through `da_i[7:0]` in that order, each byte LSB first, using the reflected polynomial 0xEDB88320 and no final inversion. The index is CRC bits 6:1. Index bits 2:0 select the row and index bits 5:3 select the bit in that row. The address is accepted when the selected bit is 1.
- R7: When `hash_we_i` is high at a clock edge, row `hash_row_i` takes the value `hash_data_i`, with data bit j stored as table bit j. Decisions sampled from the next edge onward use the new contents. The other rows are unchanged.
- R8: Reset clears `dec_valid_o`, `accept_o`, the class flags and every hash table bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| da_valid_i | input | 1 | Destination address strobe |
| da_i | input | 48 | Destination address, first wire byte in [47:40] |
| station_addr_i | input | 48 | Programmed station address |
| promisc_i | input | 1 | Promiscuous enable |
| rx_all_mc_i | input | 1 | Enables the multicast hash path |
| rx_bc_i | input | 1 | Broadcast reception enable |
| pause_i | input | 1 | Frame is a pause frame |
| hash_we_i | input | 1 | Hash row write enable |
| hash_row_i | input | 3 | Hash row address |
| hash_data_i | input | 8 | Hash row write data |
| dec_valid_o | output | 1 | Decision strobe |
| accept_o | output | 1 | Frame accepted |
| is_ucast_o | output | 1 | Unicast class |
| is_mcast_o | output | 1 | Multicast class |
| is_bcast_o | output | 1 | Broadcast class |

## Verification
The bench uses the default parameters: a 48-bit address and a hash table of 8 rows by 8 bits. With these values every table bit can be reached by a 6-bit index, and the bench computes the expected index for each multicast address on its own. To prove that lookup follows the computed index, the bench sets the target bit, clears it, and also sets neighbouring bits in the table. The unicast, broadcast and pause overrides are each exercised with the relevant enables both on and off.

// File: rtl/eth_da_filter_pkg.sv
package eth_da_filter_pkg;
  typedef enum logic [1:0] {
    DA_UCAST = 2'd0,
    DA_MCAST = 2'd1,
    DA_BCAST = 2'd2
  } da_class_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
endpackage

// File: rtl/da_classify.sv
module da_classify
  import eth_da_filter_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] da_i,
  output da_class_e         cls_o
);
  // group bit is bit 0 of the first wire byte
  localparam int GROUP_BIT = ADDR_W - 8;

  always_comb begin
    if (&da_i)               cls_o = DA_BCAST;
    else if (da_i[GROUP_BIT]) cls_o = DA_MCAST;
    else                     cls_o = DA_UCAST;
  end
endmodule

// File: rtl/da_crc_hash.sv
module da_crc_hash
  import eth_da_filter_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int HASH_W   = 6,
  parameter int HASH_LSB = 1
) (
  input  logic [ADDR_W-1:0] da_i,
  output logic [HASH_W-1:0] idx_o
);
  localparam int NBYTES = ADDR_W / 8;

  logic [31:0] crc;

  always_comb begin
    crc = CRC_INIT;
    for (int b = NBYTES - 1; b >= 0; b--) begin
      crc[7:0] = crc[7:0] ^ da_i[b*8 +: 8];
      for (int k = 0; k < 8; k++) begin
        crc = crc[0] ? ((crc >> 1) ^ CRC_POLY) : (crc >> 1);
      end
    end
    idx_o = crc[HASH_LSB +: HASH_W];
  end
endmodule

// File: rtl/mc_hash_table.sv
module mc_hash_table #(
  parameter int ROWS  = 8,
  parameter int ROW_W = 8,
  localparam int RSEL_W = $clog2(ROWS),
  localparam int BSEL_W = $clog2(ROW_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RSEL_W-1:0] wrow_i,
  input  logic [ROW_W-1:0]  wdata_i,
  input  logic [RSEL_W-1:0] rrow_i,
  input  logic [BSEL_W-1:0] rbit_i,
  output logic              hit_o
);
  logic [ROW_W-1:0] rows_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               rows_q[r] <= '0;
      else if (we_i && wrow_i == RSEL_W'(r))     rows_q[r] <= wdata_i;
    end
  end

  assign hit_o = rows_q[rrow_i][rbit_i];

  AST_ROW_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rows_q[$past(wrow_i)] == $past(wdata_i)); // R7
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import eth_da_filter_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int HASH_ROWS  = 8,
  parameter int HASH_ROW_W = 8,
  localparam int RSEL_W = $clog2(HASH_ROWS),
  localparam int BSEL_W = $clog2(HASH_ROW_W),
  localparam int HASH_W = RSEL_W + BSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              da_valid_i,
  input  logic [ADDR_W-1:0] da_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              promisc_i,
  input  logic              rx_all_mc_i,
  input  logic              rx_bc_i,
  input  logic              pause_i,
  input  logic              hash_we_i,
  input  logic [RSEL_W-1:0] hash_row_i,
  input  logic [HASH_ROW_W-1:0] hash_data_i,
  output logic              dec_valid_o,
  output logic              accept_o,
  output logic              is_ucast_o,
  output logic              is_mcast_o,
  output logic              is_bcast_o
);
  da_class_e         cls;
  logic [HASH_W-1:0] idx;
  logic              hash_hit;
  logic              accept_d;

  da_classify #(.ADDR_W(ADDR_W)) u_cls (
    .da_i  (da_i),
    .cls_o (cls)
  );

  da_crc_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .HASH_LSB(1)) u_crc (
    .da_i  (da_i),
    .idx_o (idx)
  );

  mc_hash_table #(.ROWS(HASH_ROWS), .ROW_W(HASH_ROW_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hash_we_i),
    .wrow_i  (hash_row_i),
    .wdata_i (hash_data_i),
    .rrow_i  (idx[RSEL_W-1:0]),
    .rbit_i  (idx[HASH_W-1:RSEL_W]),
    .hit_o   (hash_hit)
  );

  always_comb begin
    unique case (cls)
      DA_BCAST: accept_d = promisc_i | rx_bc_i;
      DA_MCAST: accept_d = rx_all_mc_i ? hash_hit : pause_i;
      default:  accept_d = promisc_i | (da_i == station_addr_i);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      is_ucast_o  <= 1'b0;
      is_mcast_o  <= 1'b0;
      is_bcast_o  <= 1'b0;
    end else begin
      dec_valid_o <= da_valid_i;
      if (da_valid_i) begin
        accept_o   <= accept_d;
        is_ucast_o <= (cls == DA_UCAST);
        is_mcast_o <= (cls == DA_MCAST);
        is_bcast_o <= (cls == DA_BCAST);
      end
    end
  end

  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $countones({is_ucast_o, is_mcast_o, is_bcast_o}) == 1); // R1
  AST_UC_MISMATCH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && !(&da_i) && !da_i[ADDR_W-8] && da_i != station_addr_i && !promisc_i)
      |=> !accept_o); // R3
  AST_BC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && (&da_i)) |=> accept_o == $past(promisc_i | rx_bc_i)); // R4
  AST_MC_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_valid_i && !(&da_i) && da_i[ADDR_W-8] && !rx_all_mc_i) |=> accept_o == $past(pause_i)); // R5
  AST_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(da_valid_i)); // R2
endmodule

// File: tb/eth_da_filter_test.sv
module eth_da_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        da_valid = 0;
  logic [47:0] da = '0;
  logic [47:0] station = 48'h02_11_22_33_44_55;
  logic        promisc = 0, rx_all_mc = 0, rx_bc = 0, pause = 0;
  logic        hash_we = 0;
  logic [2:0]  hash_row = '0;
  logic [7:0]  hash_data = '0;
  logic        dec_valid, accept, is_uc, is_mc, is_bc;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_da_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .da_valid_i(da_valid), .da_i(da),
    .station_addr_i(station), .promisc_i(promisc), .rx_all_mc_i(rx_all_mc),
    .rx_bc_i(rx_bc), .pause_i(pause), .hash_we_i(hash_we),
    .hash_row_i(hash_row), .hash_data_i(hash_data), .dec_valid_o(dec_valid),
    .accept_o(accept), .is_ucast_o(is_uc), .is_mcast_o(is_mc), .is_bcast_o(is_bc)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] hash_idx(logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 5; b >= 0; b--) begin
      c[7:0] ^= a[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[6:1];
  endfunction

  // present one address, check decision in the cycle after the strobe
  task automatic decide(string req, logic [47:0] a, logic exp_acc, logic [2:0] exp_cls);
    @(negedge clk);
    da = a; da_valid = 1;
    @(negedge clk);
    da_valid = 0;
    check("R2", "dec_valid", {7'd0, dec_valid}, 8'd1);
    check(req, "accept", {7'd0, accept}, {7'd0, exp_acc});
    check("R1", "class {u,m,b}", {5'd0, is_uc, is_mc, is_bc}, {5'd0, exp_cls});
    @(negedge clk);
    check("R2", "dec_valid drop", {7'd0, dec_valid}, 8'd0);
  endtask

  task automatic write_row(logic [2:0] r, logic [7:0] d);
    @(negedge clk);
    hash_we = 1; hash_row = r; hash_data = d;
    @(negedge clk);
    hash_we = 0;
  endtask

  task automatic t_reset;
    check("R8", "dec_valid", {7'd0, dec_valid}, 8'd0);
    check("R8", "flags", {4'd0, accept, is_uc, is_mc, is_bc}, 8'd0);
    rx_all_mc = 1;
    decide("R8", 48'h01_00_5E_00_00_01, 1'b0, 3'b010);
    decide("R8", 48'h33_33_00_00_00_01, 1'b0, 3'b010);
    rx_all_mc = 0;
  endtask

  task automatic t_unicast;
    decide("R3", station, 1'b1, 3'b100);
    decide("R3", 48'h02_11_22_33_44_54, 1'b0, 3'b100);
    decide("R3", 48'h00_00_00_00_00_00, 1'b0, 3'b100);
    promisc = 1;
    decide("R3", 48'h02_11_22_33_44_54, 1'b1, 3'b100);
    promisc = 0;
  endtask

  task automatic t_broadcast;
    decide("R4", 48'hFFFF_FFFF_FFFF, 1'b0, 3'b001);
    rx_bc = 1;
    decide("R4", 48'hFFFF_FFFF_FFFF, 1'b1, 3'b001);
    rx_bc = 0; promisc = 1;
    decide("R4", 48'hFFFF_FFFF_FFFF, 1'b1, 3'b001);
    promisc = 0;
  endtask

  task automatic t_mc_gate;
    write_row(3'd0, 8'hFF); write_row(3'd1, 8'hFF); write_row(3'd2, 8'hFF); write_row(3'd3, 8'hFF);
    write_row(3'd4, 8'hFF); write_row(3'd5, 8'hFF); write_row(3'd6, 8'hFF); write_row(3'd7, 8'hFF);
    decide("R5", 48'h01_00_5E_00_00_01, 1'b0, 3'b010);
    pause = 1;
    decide("R5", 48'h01_80_C2_00_00_01, 1'b1, 3'b010);
    pause = 0;
    for (int r = 0; r < 8; r++) write_row(r[2:0], 8'h00);
  endtask

  task automatic t_hash(logic [47:0] a);
    logic [5:0] ix = hash_idx(a);
    logic [7:0] one = 8'd1 << ix[5:3];
    rx_all_mc = 1;
    write_row(ix[2:0], one);
    decide("R6", a, 1'b1, 3'b010);
    write_row(ix[2:0], ~one);
    write_row(ix[2:0] + 3'd1, 8'hFF);
    decide("R6", a, 1'b0, 3'b010);
    write_row(ix[2:0], one);
    decide("R7", a, 1'b1, 3'b010);
    write_row(ix[2:0], 8'h00);
    write_row(ix[2:0] + 3'd1, 8'h00);
    decide("R7", a, 1'b0, 3'b010);
    rx_all_mc = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_mc_gate();
    t_hash(48'h01_00_5E_00_00_01);
    t_hash(48'h33_33_00_00_00_01);
    t_hash(48'h01_00_5E_7F_12_34);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule